// File: doc/BRIEF.md
# Bus Cycle Length Controller

This block sets the length of every processor bus cycle in master clock periods. A bus cycle starts with a request that carries the 24-bit address and a flag that marks a cycle with no memory access. The block classifies the address into a speed class using a fixed memory map and a stored fast-ROM enable. The class gives a length of 6, 8 or 12 master cycles. The block then counts that length and raises a one-cycle done strobe on the final master cycle.

A stall input from the video timing logic freezes the count for as long as it is high. The done strobe never appears during a stall. The block produces timing only. Chip selects and data paths sit elsewhere.

The request side is a valid/ready handshake. Ready is high only when no bus cycle is in progress. A request is taken on a clock edge where both valid and ready are high. While a cycle runs, ready is low and the requester must hold off. There is no queue, so back-pressure lasts exactly until the cycle after done.

Top module: `bus_speed_ctrl`

## Requirements
- R1: After reset, ready is 1, done is 0, and the fast-ROM enable reads as 0. With the enable at 0, a request to $808000 lasts 8 cycles.
- R2: A request with the internal flag set lasts 6 cycles, whatever its address.
- R3: Work RAM lasts 8 cycles. Work RAM is bank $7E–$7F, plus offset $0000–$1FFF in banks $00–$3F and $80–$BF.
- R4: In banks $00–$3F and $80–$BF, offsets $2100–$21FF and $4200–$43FF last 6 cycles.
- R5: In banks $00–$3F and $80–$BF, offsets $4000–$41FF last 12 cycles.
- R6: A ROM access at address $800000 or above lasts 6 cycles when the fast-ROM enable is 1. ROM means banks $C0–$FF, or offset bit 15 set in banks $80–$BF.
- R7: All other ROM accesses last 8 cycles. This covers banks $40–$7D, offset bit 15 set in banks $00–$3F, and any high-bank ROM while the enable is 0.
- R8: The remaining offsets in banks $00–$3F and $80–$BF last 8 cycles. These are $2000–$20FF, $2200–$3FFF and $4400–$7FFF.
- R9: When stall is high, the count holds and done stays 0. The done strobe comes on the N-th master cycle after acceptance that has stall low, where N is the length.
- R10: Done is high for exactly one master cycle. Ready is low from the acceptance edge until done, and high again on the next master cycle.
- R11: A write to the fast-ROM enable applies from the next accepted request. A write made in the same cycle as acceptance, or while a cycle runs, does not change that cycle's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start request for a bus cycle |
| req_ready_o | output | 1 | High when a request can be accepted |
| req_addr_i | input | 24 | Bank (bits 23:16) and offset (bits 15:0) of the access |
| req_internal_i | input | 1 | Cycle with no memory access |
| fast_wr_i | input | 1 | Write strobe for the fast-ROM enable |
| fast_val_i | input | 1 | Value written to the fast-ROM enable |
| stall_i | input | 1 | Refresh stall; freezes the count |
| done_o | output | 1 | One-cycle strobe on the last master cycle of a bus cycle |

## Verification
The assertions assume that requests arrive only while ready is high. They also assume that the stall input is a plain level, which may take any value on any cycle, including the cycle that would carry done. The bench raises valid only after it sees ready at a falling edge. It drops valid right after acceptance, drives stall from $urandom at a fixed percentage on every busy cycle, and writes the fast-ROM enable at acceptance and in the middle of cycles.

// File: rtl/bus_speed_pkg.sv
package bus_speed_pkg;
  // Speed class chosen for one bus cycle
  typedef enum logic [1:0] {
    SPD_FAST  = 2'd0,
    SPD_SLOW  = 2'd1,
    SPD_XSLOW = 2'd2
  } speed_e;

  // Region tag used by the decoder
  typedef enum logic [2:0] {
    RG_WRAM   = 3'd0,
    RG_ROM    = 3'd1,
    RG_REGS   = 3'd2,
    RG_SERIAL = 3'd3,
    RG_OTHER  = 3'd4
  } region_e;
endpackage

// File: rtl/bus_region_decode.sv
module bus_region_decode
  import bus_speed_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              internal_i,
  input  logic              fast_en_i,
  output speed_e            speed_o
);
  localparam int OFF_W  = 16;
  localparam int BANK_W = ADDR_W - OFF_W;

  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic              sys_bank;
  logic              high_half;
  region_e           region;

  assign bank      = addr_i[ADDR_W-1:OFF_W];
  assign off       = addr_i[OFF_W-1:0];
  // banks $00-$3F and $80-$BF carry the system window
  assign sys_bank  = (bank[BANK_W-2] == 1'b0);
  assign high_half = bank[BANK_W-1];

  always_comb begin
    region = RG_OTHER;
    if (bank[BANK_W-1:1] == 7'h3F) begin
      region = RG_WRAM;
    end else if (!sys_bank) begin
      region = RG_ROM;
    end else if (off < 16'h2000) begin
      region = RG_WRAM;
    end else if (off[OFF_W-1]) begin
      region = RG_ROM;
    end else if (off[15:8] == 8'h21) begin
      region = RG_REGS;
    end else if (off[15:9] == 7'b0100_001) begin
      region = RG_REGS;
    end else if (off[15:9] == 7'b0100_000) begin
      region = RG_SERIAL;
    end
  end

  always_comb begin
    if (internal_i) begin
      speed_o = SPD_FAST;
    end else begin
      unique case (region)
        RG_REGS:   speed_o = SPD_FAST;
        RG_SERIAL: speed_o = SPD_XSLOW;
        RG_ROM:    speed_o = (high_half && fast_en_i) ? SPD_FAST : SPD_SLOW;
        default:   speed_o = SPD_SLOW;
      endcase
    end
  end

  // R2: an internal cycle is always fast
  always_comb begin
    a_r2_internal_fast: assert (!internal_i || speed_o == SPD_FAST);
  end
  // R6/R7: a fast class outside internal cycles and registers needs the enable
  always_comb begin
    a_r6_fast_needs_enable: assert (internal_i || region == RG_REGS ||
                                    speed_o != SPD_FAST || fast_en_i);
  end
endmodule

// File: rtl/bus_cycle_counter.sv
module bus_cycle_counter #(
  parameter int MAX_LEN = 12,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             stall_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && !stall_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= len_i;
      busy_q <= 1'b1;
    end else if (busy_q && !stall_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  // R9: a stall freezes the count and keeps the cycle open
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stall_i && !load_i) |=> ($stable(cnt_q) && busy_q));
  // R9: no done while stalled
  a_r9_no_done_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !done_o);
  // R10: done lasts one cycle
  a_r10_done_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: the count stays inside the legal range while busy
  a_r10_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0 && cnt_q <= CNT_W'(MAX_LEN)));
  // R10: a load is only taken when idle
  a_r10_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q);
endmodule

// File: rtl/bus_speed_ctrl.sv
module bus_speed_ctrl
  import bus_speed_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_FAST  = 6,
  parameter int LEN_SLOW  = 8,
  parameter int LEN_XSLOW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_internal_i,
  input  logic              fast_wr_i,
  input  logic              fast_val_i,
  input  logic              stall_i,
  output logic              done_o
);
  localparam int CNT_W = $clog2(LEN_XSLOW + 1);

  logic             fast_q;
  speed_e           speed;
  logic [CNT_W-1:0] len;
  logic             busy;
  logic             accept;

  // enable register: written value is seen by the next accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fast_q <= 1'b0;
    else if (fast_wr_i) fast_q <= fast_val_i;
  end

  bus_region_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i     (req_addr_i),
    .internal_i (req_internal_i),
    .fast_en_i  (fast_q),
    .speed_o    (speed)
  );

  always_comb begin
    unique case (speed)
      SPD_FAST:  len = CNT_W'(LEN_FAST);
      SPD_XSLOW: len = CNT_W'(LEN_XSLOW);
      default:   len = CNT_W'(LEN_SLOW);
    endcase
  end

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;

  bus_cycle_counter #(.MAX_LEN(LEN_XSLOW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .len_i   (len),
    .stall_i (stall_i),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  // R10: ready drops after acceptance
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready_o);
  // R10: ready returns right after done
  a_r10_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> req_ready_o);
  // R10: done only within a running cycle
  a_r10_done_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_ready_o);
endmodule

// File: tb/bus_speed_ctrl_bench.sv
`timescale 1ns/1ps
module bus_speed_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_internal = 1'b0;
  logic        fast_wr = 1'b0;
  logic        fast_val = 1'b0;
  logic        stall = 1'b0;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit fast_m = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_speed_ctrl u_bus_speed_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_internal_i(req_internal), .fast_wr_i(fast_wr),
    .fast_val_i(fast_val), .stall_i(stall), .done_o(done)
  );

  function automatic int exp_len(logic [23:0] a, bit intl, bit fast);
    logic [7:0]  b = a[23:16];
    logic [15:0] o = a[15:0];
    if (intl) return 6;
    if (b == 8'h7E || b == 8'h7F) return 8;
    if ((b >= 8'h40 && b <= 8'h7D) || b >= 8'hC0) return (fast && b >= 8'h80) ? 6 : 8;
    if (o < 16'h2000) return 8;
    if (o >= 16'h8000) return (fast && b >= 8'h80) ? 6 : 8;
    if ((o >= 16'h2100 && o <= 16'h21FF) || (o >= 16'h4200 && o <= 16'h43FF)) return 6;
    if (o >= 16'h4000 && o <= 16'h41FF) return 12;
    return 8;
  endfunction

  function automatic string req_of(logic [23:0] a, bit intl, bit fast);
    logic [7:0]  b = a[23:16];
    logic [15:0] o = a[15:0];
    if (intl) return "R2";
    if (b == 8'h7E || b == 8'h7F) return "R3";
    if ((b >= 8'h40 && b <= 8'h7D) || b >= 8'hC0 || o >= 16'h8000)
      return (fast && b >= 8'h80) ? "R6" : "R7";
    if (o < 16'h2000) return "R3";
    if ((o >= 16'h2100 && o <= 16'h21FF) || (o >= 16'h4200 && o <= 16'h43FF)) return "R4";
    if (o >= 16'h4000 && o <= 16'h41FF) return "R5";
    return "R8";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle; called and returns at a falling edge with ready expected high
  task automatic do_bus(logic [23:0] a, bit intl, int stall_pct,
                        bit wr_start, bit wr_val, bit wr_mid, string tag);
    int exp, cyc, st;
    bit got;
    string rq;
    rq  = (tag != "") ? tag : req_of(a, intl, fast_m);
    exp = exp_len(a, intl, fast_m);
    check(req_ready == 1'b1, "R10", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = a; req_internal = intl;
    fast_wr = wr_start; fast_val = wr_val;
    @(posedge clk);
    if (wr_start) fast_m = wr_val;
    cyc = 0; st = 0; got = 1'b0;
    while (!got && cyc < 64) begin
      @(negedge clk);
      req_valid = 1'b0;
      stall = (($urandom % 100) < stall_pct);
      if (wr_mid && cyc == 1) begin fast_wr = 1'b1; fast_val = ~fast_m; end
      else fast_wr = 1'b0;
      #1;
      if (fast_wr) fast_m = fast_val;
      cyc++;
      if (req_ready) check(1'b0, "R10", 1, 0);
      if (stall) begin
        st++;
        if (done) check(1'b0, "R9", 1, 0);
      end else if (done) got = 1'b1;
    end
    check(got && (cyc - st) == exp, rq, cyc - st, exp);
    @(negedge clk);
    stall = 1'b0; fast_wr = 1'b0;
    #1;
    check(req_ready == 1'b1 && done == 1'b0, "R10", {req_ready, done}, 2);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", int'(req_ready), 1);
    check(done == 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_bus(24'h808000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R1");
    // directed corners, enable off
    do_bus(24'hC01234, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R2");
    do_bus(24'h7E0000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R3");
    do_bus(24'h801FFF, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R3");
    do_bus(24'h002100, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R4");
    do_bus(24'h0043FF, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R4");
    do_bus(24'h004000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R5");
    do_bus(24'h8041FF, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R5");
    do_bus(24'h7DFFFF, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R7");
    do_bus(24'hC00000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R7");
    do_bus(24'h002000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R8");
    do_bus(24'h804400, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R8");
    // R11: enable written at acceptance: this cycle still slow, next fast
    do_bus(24'hC00000, 1'b0, 0, 1'b1, 1'b1, 1'b0, "R11");
    do_bus(24'hC00000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6");
    do_bus(24'h808000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6");
    do_bus(24'h008000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R7");
    do_bus(24'h7F0000, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R3");
    // R11: mid-cycle write leaves the running cycle alone
    do_bus(24'hFFFFFF, 1'b0, 0, 1'b0, 1'b0, 1'b1, "R11");
    do_bus(24'hFFFFFF, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R7");
    // R9: heavy stalls
    do_bus(24'h804016, 1'b0, 60, 1'b0, 1'b0, 1'b0, "R9");
    do_bus(24'h7E8000, 1'b0, 60, 1'b0, 1'b0, 1'b0, "R9");
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [23:0] a;
      int k;
      a = $urandom;
      k = $urandom % 6;
      if (k == 0) a[15:9] = 7'b0100_000;
      else if (k == 1) a[15:8] = 8'h21;
      else if (k == 2) a[15:13] = 3'b000;
      if (k < 3) a[22] = 1'b0;
      do_bus(a, ($urandom % 8) == 0, 25, ($urandom % 10) == 0, $urandom % 2,
             ($urandom % 10) == 0, "");
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule